// File: doc/BRIEF.md
# HL Pair Add/Subtract With Carry Unit

This unit performs the 16-bit carry-propagating arithmetic of an 8-bit CPU core on its HL register pair. It either adds a chosen 16-bit source plus the current carry flag to HL, or subtracts the source and the carry flag from HL. The source is BC, DE, HL itself or the stack pointer, chosen by two opcode bits. Another opcode bit chooses between add and subtract.

The sum is not formed by one 16-bit adder. It is formed by a chain of byte-wide stages. The low byte is computed first. Its carry or borrow feeds the high byte. Most flags come from the most significant stage. The zero flag alone looks at the whole 16-bit result.

The sequencer presents operands with a one-cycle `op_valid` strobe. One clock later it receives the new HL and the new flag byte, together with `res_valid`. A constant port tells the sequencer how many clock states the instruction costs.

Top module: `hl16_adcsbc`

## Requirements
- R1: While reset is asserted and after it is released, `hl_out` and `flags_out` are zero and `res_valid` is low until the first operation.
- R2: Opcode bits 5:4 select the source word: 00 = BC, 01 = DE, 10 = HL (the `hl_in` value itself), 11 = SP (its low and high bytes used as the two byte operands).
- R3: Opcode bit 3 = 1 gives HL + source + C and bit 3 = 0 gives HL − source − C, where C is `flags_in` bit 0. The result appears on `hl_out` on the clock edge after the edge that samples `op_valid`, and `res_valid` is high in that same cycle.
- R4: The carry or borrow out of the low byte is used as the carry-in of the high byte. For example, 0x00FF + 0x0001 with carry 0 gives 0x0100.
- R5: Flag bit 6 (zero) is set if and only if all 16 result bits are zero. A zero high byte with a non-zero low byte leaves it clear.
- R6: Flag bit 7 (sign) equals result bit 15. Flag bit 0 (carry) is the carry (add) or borrow (subtract) out of bit 15.
- R7: Flag bit 4 (half-carry) is the carry or borrow out of bit 11.
- R8: Flag bit 2 (overflow) is set when the 16-bit two's-complement operation overflows.
- R9: Flag bit 1 is 0 for add and 1 for subtract. Flag bits 5 and 3 copy result bits 13 and 11.
- R10: Opcode bits 7:6 and 2:0, and `flags_in` bits 7:1, have no effect on `hl_out` or `flags_out`.
- R11: In a cycle after `op_valid` was low, `res_valid` is low and `hl_out` and `flags_out` keep their values, whatever the inputs do.
- R12: `cycle_cost` reports a constant 15 clock states for both the add and the subtract form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operands and opcode valid this cycle |
| opcode | input | 8 | Opcode byte; bit 3 is the operation, bits 5:4 are the source |
| hl_in | input | 16 | Current HL pair |
| bc_in | input | 16 | Current BC pair |
| de_in | input | 16 | Current DE pair |
| sp_in | input | 16 | Current stack pointer |
| flags_in | input | 8 | Current flag byte; bit 0 is carry |
| hl_out | output | 16 | New HL value |
| flags_out | output | 8 | New flag byte |
| res_valid | output | 1 | `hl_out`/`flags_out` hold a fresh result |
| cycle_cost | output | 8 | Clock-state cost of the instruction |

## Verification
Each operation driven on a falling edge is captured on the next rising edge. Its HL value and flag byte are then due one time unit after that edge, with `res_valid` high. The driver pushes the expected pair into a queue at the moment it drives the operands. The monitor pops one entry at every post-edge sample in which `res_valid` is high, so back-to-back operations line up one for one. In post-edge samples where `res_valid` is low, the monitor compares the outputs against the last result to confirm they are held. Every queue entry is computed from a 17-bit whole-word model. That model does not use byte chaining.

// File: rtl/hl16_arith_pkg.sv
package hl16_arith_pkg;
  // Opcode field positions the sequencer decodes
  localparam int OPC_OP_BIT = 3;
  localparam int OPC_SEL_LO = 4;
  localparam int OPC_SEL_HI = 5;

  // Flag byte layout
  localparam int FLAG_W  = 8;
  localparam int FLG_C   = 0;
  localparam int FLG_N   = 1;
  localparam int FLG_PV  = 2;
  localparam int FLG_X3  = 3;
  localparam int FLG_H   = 4;
  localparam int FLG_X5  = 5;
  localparam int FLG_Z   = 6;
  localparam int FLG_S   = 7;

  typedef enum logic [1:0] {
    SRC_BC = 2'b00,
    SRC_DE = 2'b01,
    SRC_HL = 2'b10,
    SRC_SP = 2'b11
  } src_sel_e;

  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } op_kind_e;
endpackage

// File: rtl/hl16_pair_select.sv
module hl16_pair_select
  import hl16_arith_pkg::*;
#(
  parameter int W = 16
) (
  input  src_sel_e       sel,
  input  logic [W-1:0]   bc,
  input  logic [W-1:0]   de,
  input  logic [W-1:0]   hl,
  input  logic [W-1:0]   sp,
  output logic [W-1:0]   src
);
  always_comb begin
    unique case (sel)
      SRC_BC:  src = bc;
      SRC_DE:  src = de;
      SRC_HL:  src = hl;
      default: src = sp;
    endcase
  end
endmodule

// File: rtl/hl16_byte_stage.sv
module hl16_byte_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         half,
  output logic         ovf
);
  localparam int HW = W / 2;

  // Extended add/subtract; top bit is carry (add) or borrow (sub)
  function automatic logic [W:0] full_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic s, input logic c);
    logic [W:0] xe, ye, ce;
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{W{1'b0}}, c};
    return s ? (xe - ye - ce) : (xe + ye + ce);
  endfunction

  function automatic logic [HW:0] nib_op(input logic [HW-1:0] x, input logic [HW-1:0] y,
                                         input logic s, input logic c);
    logic [HW:0] xe, ye, ce;
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{HW{1'b0}}, c};
    return s ? (xe - ye - ce) : (xe + ye + ce);
  endfunction

  logic [W:0]  wide;
  logic [HW:0] low_nib;

  always_comb begin
    wide    = full_op(a, b, sub, cin);
    low_nib = nib_op(a[HW-1:0], b[HW-1:0], sub, cin);
    res     = wide[W-1:0];
    cout    = wide[W];
    half    = low_nib[HW];
    if (sub) ovf = (a[W-1] ^ b[W-1]) & (a[W-1] ^ wide[W-1]);
    else     ovf = ~(a[W-1] ^ b[W-1]) & (a[W-1] ^ wide[W-1]);
  end
endmodule

// File: rtl/hl16_flag_merge.sv
module hl16_flag_merge
  import hl16_arith_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      result,
  input  logic              sub,
  input  logic              half_top,
  input  logic              ovf_top,
  input  logic              carry_top,
  output logic [FLAG_W-1:0] flags
);
  logic word_zero;
  assign word_zero = (result == '0);

  always_comb begin
    flags         = '0;
    flags[FLG_S]  = result[W-1];
    flags[FLG_Z]  = word_zero;
    flags[FLG_X5] = result[W-3];
    flags[FLG_H]  = half_top;
    flags[FLG_X3] = result[W-5];
    flags[FLG_PV] = ovf_top;
    flags[FLG_N]  = sub;
    flags[FLG_C]  = carry_top;
  end
endmodule

// File: rtl/hl16_adcsbc.sv
module hl16_adcsbc
  import hl16_arith_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int OPC_W  = 8,
  parameter int COST_W = 8,
  parameter int COST   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] hl_in,
  input  logic [DATA_W-1:0] bc_in,
  input  logic [DATA_W-1:0] de_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DATA_W-1:0] hl_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic              res_valid,
  output logic [COST_W-1:0] cycle_cost
);
  localparam int NB = DATA_W / BYTE_W;

  src_sel_e          src_sel;
  op_kind_e          op_kind;
  logic              is_sub;
  logic [DATA_W-1:0] src_word;
  logic [NB:0]       chain_carry;
  logic [NB-1:0]     stage_half;
  logic [NB-1:0]     stage_ovf;
  logic [DATA_W-1:0] sum_next;
  logic [FLAG_W-1:0] flags_next;

  assign src_sel = src_sel_e'(opcode[OPC_SEL_HI:OPC_SEL_LO]);
  assign op_kind = op_kind_e'(opcode[OPC_OP_BIT]);
  assign is_sub  = (op_kind == OP_SUB);

  hl16_pair_select #(.W(DATA_W)) u_sel (
    .sel (src_sel),
    .bc  (bc_in),
    .de  (de_in),
    .hl  (hl_in),
    .sp  (sp_in),
    .src (src_word)
  );

  assign chain_carry[0] = flags_in[FLG_C];

  for (genvar g = 0; g < NB; g++) begin : g_stage
    hl16_byte_stage #(.W(BYTE_W)) u_stage (
      .a    (hl_in[g*BYTE_W +: BYTE_W]),
      .b    (src_word[g*BYTE_W +: BYTE_W]),
      .sub  (is_sub),
      .cin  (chain_carry[g]),
      .res  (sum_next[g*BYTE_W +: BYTE_W]),
      .cout (chain_carry[g+1]),
      .half (stage_half[g]),
      .ovf  (stage_ovf[g])
    );
  end

  hl16_flag_merge #(.W(DATA_W)) u_flags (
    .result    (sum_next),
    .sub       (is_sub),
    .half_top  (stage_half[NB-1]),
    .ovf_top   (stage_ovf[NB-1]),
    .carry_top (chain_carry[NB]),
    .flags     (flags_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hl_out    <= '0;
      flags_out <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        hl_out    <= sum_next;
        flags_out <= flags_next;
      end
    end
  end

  assign cycle_cost = COST_W'(COST);

  // Lower-stage flags and undecoded inputs are intentionally dropped
  logic unused_bits;
  assign unused_bits = ^{stage_half, stage_ovf, opcode, flags_in};
endmodule

// File: rtl/hl16_adcsbc_chk.sv
module hl16_adcsbc_chk
  import hl16_arith_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [DATA_W-1:0] hl_out,
  input logic [FLAG_W-1:0] flags_out,
  input logic              res_valid
);
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(hl_out) && $stable(flags_out)));

  assert_zero_whole_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags_out[FLG_Z] == (hl_out == '0)));

  assert_sign_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags_out[FLG_S] == hl_out[DATA_W-1]));

  assert_sub_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flags_out[FLG_N] == !$past(opcode[OPC_OP_BIT])));

  assert_copy_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags_out[FLG_X5] == hl_out[DATA_W-3] &&
                   flags_out[FLG_X3] == hl_out[DATA_W-5]));
endmodule

bind hl16_adcsbc hl16_adcsbc_chk #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .hl_out    (hl_out),
  .flags_out (flags_out),
  .res_valid (res_valid)
);

// File: tb/tb_hl16_adcsbc.sv
`timescale 1ns/1ps
module tb_hl16_adcsbc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] hl_in = '0, bc_in = '0, de_in = '0, sp_in = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] hl_out;
  logic [7:0]  flags_out;
  logic        res_valid;
  logic [7:0]  cycle_cost;

  int checks = 0;
  int fails  = 0;
  logic [23:0] exp_q[$];
  logic [23:0] last_res = '0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  hl16_adcsbc dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .hl_in(hl_in), .bc_in(bc_in), .de_in(de_in), .sp_in(sp_in),
    .flags_in(flags_in), .hl_out(hl_out), .flags_out(flags_out),
    .res_valid(res_valid), .cycle_cost(cycle_cost)
  );

  // Whole-word 17-bit reference: returns {flags, hl}
  function automatic logic [23:0] model(input logic add, input logic [15:0] hl,
                                        input logic [15:0] src, input logic cin);
    logic [16:0] w;
    logic [12:0] h;
    logic [15:0] r;
    logic        v;
    if (add) begin
      w = {1'b0, hl} + {1'b0, src} + 17'(cin);
      h = {1'b0, hl[11:0]} + {1'b0, src[11:0]} + 13'(cin);
    end else begin
      w = {1'b0, hl} - {1'b0, src} - 17'(cin);
      h = {1'b0, hl[11:0]} - {1'b0, src[11:0]} - 13'(cin);
    end
    r = w[15:0];
    if (add) v = (hl[15] == src[15]) && (r[15] != hl[15]);
    else     v = (hl[15] != src[15]) && (r[15] != hl[15]);
    return {r[15], (r == 16'h0), r[13], h[12], r[11], v, !add, w[16], r};
  endfunction

  function automatic string flag_tag(input logic [7:0] diff);
    if (diff[6]) return "R5";
    if (diff[7] || diff[0]) return "R6";
    if (diff[4]) return "R7";
    if (diff[2]) return "R8";
    return "R9";
  endfunction

  // Driver: source select (R2) and operation (R3) come from opcode bits
  task automatic apply(input logic [7:0] opc, input logic [15:0] hl, input logic [15:0] bc,
                       input logic [15:0] de, input logic [15:0] sp, input logic [7:0] fl);
    logic [15:0] src;
    @(negedge clk);
    opcode = opc; hl_in = hl; bc_in = bc; de_in = de; sp_in = sp; flags_in = fl;
    op_valid = 1'b1;
    case (opc[5:4])
      2'b00:   src = bc;
      2'b01:   src = de;
      2'b10:   src = hl;
      default: src = sp;
    endcase
    exp_q.push_back(model(opc[3], hl, src, fl[0]));
  endtask

  // Idle cycle with scrambled inputs (R11)
  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
    opcode = 8'($urandom); hl_in = 16'($urandom); bc_in = 16'($urandom);
    flags_in = 8'($urandom);
  endtask

  function automatic logic [7:0] mk(input logic [7:0] upper, input logic add, input logic [1:0] sel);
    return {upper[7:6], sel, add, upper[2:0]};
  endfunction

  // Monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3: res_valid high with no pending op, got 1 exp 0");
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          checks++;
          if (hl_out !== e[15:0]) begin
            fails++;
            $display("FAIL R2/R3/R4: hl_out got %h exp %h", hl_out, e[15:0]);
          end
          checks++;
          if (flags_out !== e[23:16]) begin
            fails++;
            $display("FAIL %s: flags_out got %b exp %b", flag_tag(flags_out ^ e[23:16]),
                     flags_out, e[23:16]);
          end
          last_res = e;
        end
      end else begin
        checks++;
        if ({flags_out, hl_out} !== last_res) begin
          fails++;
          $display("FAIL R11: held output got %h exp %h", {flags_out, hl_out}, last_res);
        end
      end
    end
  end

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (hl_out !== 16'h0 || flags_out !== 8'h0 || res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset got %h/%h/%b exp 0/0/0", hl_out, flags_out, res_valid);
    end
    // R12: constant cost
    checks++;
    if (cycle_cost !== 8'd15) begin
      fails++;
      $display("FAIL R12: cycle_cost got %0d exp 15", cycle_cost);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (hl_out !== 16'h0 || flags_out !== 8'h0 || res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: after reset got %h/%h/%b exp 0/0/0", hl_out, flags_out, res_valid);
    end

    // R4: low-byte carry into high byte
    apply(mk(8'h40, 1'b1, 2'b00), 16'h00FF, 16'h0001, 16'h0, 16'h0, 8'h00);
    // R5: high byte zero, low byte not
    apply(mk(8'h40, 1'b0, 2'b01), 16'h00FF, 16'h0, 16'h0000, 16'h0, 8'h00);
    // R5: full zero via subtract of itself
    apply(mk(8'h40, 1'b0, 2'b10), 16'h1234, 16'h0, 16'h0, 16'h0, 8'h00);
    // R5/R6: zero with carry out on add
    apply(mk(8'h40, 1'b1, 2'b11), 16'hFFFF, 16'h0, 16'h0, 16'h0000, 8'h01);
    // R7: carry out of bit 11
    apply(mk(8'h40, 1'b1, 2'b00), 16'h0FFF, 16'h0001, 16'h0, 16'h0, 8'h00);
    // R8: signed overflow add and subtract
    apply(mk(8'h40, 1'b1, 2'b01), 16'h7FFF, 16'h0, 16'h0001, 16'h0, 8'h00);
    apply(mk(8'h40, 1'b0, 2'b11), 16'h8000, 16'h0, 16'h0, 16'h0001, 8'h00);
    // R6: borrow from zero with carry-in; R2 SP byte split
    apply(mk(8'h40, 1'b0, 2'b11), 16'h0000, 16'h0, 16'h0, 16'h00FF, 8'h01);
    idle(); idle();
    // R2: HL as source doubles; R10 upper opcode/flag bits scrambled
    apply(mk(8'hC7, 1'b1, 2'b10), 16'h4321, 16'hAAAA, 16'h5555, 16'h0F0F, 8'hFE);
    apply(mk(8'h07, 1'b0, 2'b00), 16'h5000, 16'h2FFF, 16'h0, 16'h0, 8'hFF);
    idle();

    // Random sweep over all sources and both operations (R2, R3, R10)
    for (int i = 0; i < 400; i++) begin
      apply(8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            16'($urandom), 8'($urandom));
      if (($urandom % 4) == 0) idle();
    end
    idle(); idle(); idle();
    done = 1'b1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3: pending results got %0d exp 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule